// File: doc/BRIEF.md
# Set/Clear GPIO Port Register Bank

This block is the register side of a 32-pin general-purpose I/O port. A processor reaches it through a plain memory-mapped port: a byte address, a write strobe, write data and combinational read data. Per-pin output value and direction are held in the block and are never written as whole words. Software changes them through separate set and clear strobes, so it can change one pin without a read-modify-write sequence and without disturbing pins owned by other code.

The block also holds a per-pin pull-disable mask, a per-pin sleep "keep state" mask and two alternate-function masks whose bits combine per pin into a two-bit function code for the pad multiplexer. Pin levels arrive asynchronously, pass through a two-flop synchronizer and can be read back. The pad layer receives the output value, output enable, pull enable, sleep-keep mask and a packed vector of function codes.

Top module: `gpio_port_bank`

## Requirements
- R1: After reset every pin is an input (direction reads 0, `pad_oe` is 0), output data is 0, pull-disable, sleep-keep, alt-A and alt-B read 0, every function code is 00 and `pad_pull_en` is all ones.
- R2: A write to offset 0x04 (data set) makes the output value 1 for every pin whose written bit is 1; pins with written bit 0 keep their value. The new value shows on `pad_out` after the write edge.
- R3: A write to offset 0x08 (data clear) makes the output value 0 for every pin whose written bit is 1; the other pins keep their value.
- R4: A 1 written to offset 0x14 makes the pin an output and a 1 written to offset 0x18 makes it an input; other pins keep their direction. Offset 0x10 reads the direction (1 = output) and `pad_oe` equals it.
- R5: Offset 0x00 reads the pin levels after a two-flop synchronizer: a change on `pin_in` before a clock edge is still unseen after that edge and is visible after the next one.
- R6: Offsets 0x20 (alt-A) and 0x24 (alt-B) are read/write masks. Pin i's code `pad_func[2i+1:2i]` is {alt-B bit i, alt-A bit i}: 00 GPIO, 01 function A, 10 function B, 11 function C.
- R7: Offset 0x0C is a read/write pull-disable mask; `pad_pull_en` is its bitwise inverse (1 in the mask turns the pull off).
- R8: Offset 0x1C is a read/write sleep mask; a 1 selects "no change" sleep behaviour for the pin and appears on `pad_sleep_keep`.
- R9: The set and clear offsets (0x04, 0x08, 0x14, 0x18) and every unmapped address read as 0; writes to unmapped addresses change no state.
- R10: Writes to offset 0x00 are ignored, and `pad_out` carries the stored output value whether or not the pin is an output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 6 | Byte address of the register |
| wr_en | input | 1 | Write strobe, one write per asserted cycle |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr`, combinational |
| pin_in | input | 32 | Asynchronous pin levels from the pads |
| pad_out | output | 32 | Output value per pin |
| pad_oe | output | 32 | Output enable per pin (1 = drive) |
| pad_pull_en | output | 32 | Pull enable per pin |
| pad_sleep_keep | output | 32 | Sleep "no change" select per pin |
| pad_func | output | 64 | Two-bit function code per pin, pin i in bits 2i+1:2i |

## Verification
A wrong bit in the stored output or direction state appears on `pad_out` or `pad_oe` on the cycle right after the faulty write, and stays wrong until the next set or clear touching that pin. So each strobe is followed at once by a check of the pad vectors and of pins the write should have left alone. A swapped alt-A/alt-B bit shows up only as a wrong function code on the pad side, which is checked per pin for all four codes. A synchronizer with the wrong depth shows as a read of the data register one cycle early or late, which is sampled after each of the two edges.

// File: rtl/gpb_pkg.sv
package gpb_pkg;

    localparam int unsigned PIN_N   = 32;
    localparam int unsigned ADDR_W  = 6;
    localparam int unsigned FN_W    = 2;
    localparam int unsigned FUNC_W  = PIN_N * FN_W;
    localparam int unsigned SYNC_N  = 2;

    // Register selection decoded from the byte address
    typedef enum logic [3:0] {
        SEL_DATA,
        SEL_DSET,
        SEL_DCLR,
        SEL_PDIS,
        SEL_DIR,
        SEL_DIRS,
        SEL_DIRC,
        SEL_SLP,
        SEL_ALTA,
        SEL_ALTB,
        SEL_NONE
    } reg_sel_e;

    // Pad function code, upper bit from alt-B, lower bit from alt-A
    typedef enum logic [FN_W-1:0] {
        FN_GPIO = 2'b00,
        FN_A    = 2'b01,
        FN_B    = 2'b10,
        FN_C    = 2'b11
    } pin_fn_e;

    typedef struct packed {
        logic [PIN_N-1:0] dout;
        logic [PIN_N-1:0] dir;
        logic [PIN_N-1:0] pull_dis;
        logic [PIN_N-1:0] sleep_keep;
        logic [PIN_N-1:0] alt_a;
        logic [PIN_N-1:0] alt_b;
    } port_state_t;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            ADDR_W'('h00): s = SEL_DATA;
            ADDR_W'('h04): s = SEL_DSET;
            ADDR_W'('h08): s = SEL_DCLR;
            ADDR_W'('h0C): s = SEL_PDIS;
            ADDR_W'('h10): s = SEL_DIR;
            ADDR_W'('h14): s = SEL_DIRS;
            ADDR_W'('h18): s = SEL_DIRC;
            ADDR_W'('h1C): s = SEL_SLP;
            ADDR_W'('h20): s = SEL_ALTA;
            ADDR_W'('h24): s = SEL_ALTB;
            default:       s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic pin_fn_e pin_fn(input logic a_bit, input logic b_bit);
        return pin_fn_e'({b_bit, a_bit});
    endfunction

endpackage

// File: rtl/gpb_sync.sv
module gpb_sync #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] s1;
    logic [W-1:0] s2;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
            s2 <= '0;
        end else begin
            s1 <= d;
            s2 <= s1;
        end
    end

    assign q = s2;

    // R5
    sync_lag_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (q == $past(s1)));

endmodule

// File: rtl/gpb_regfile.sv
module gpb_regfile
    import gpb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  reg_sel_e         sel,
    input  logic [PIN_N-1:0] wr_data,
    output port_state_t      st
);

    port_state_t st_q;
    port_state_t st_d;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (sel)
                SEL_DSET: st_d.dout       = st_q.dout | wr_data;
                SEL_DCLR: st_d.dout       = st_q.dout & ~wr_data;
                SEL_DIRS: st_d.dir        = st_q.dir | wr_data;
                SEL_DIRC: st_d.dir        = st_q.dir & ~wr_data;
                SEL_PDIS: st_d.pull_dis   = wr_data;
                SEL_SLP:  st_d.sleep_keep = wr_data;
                SEL_ALTA: st_d.alt_a      = wr_data;
                SEL_ALTB: st_d.alt_b      = wr_data;
                default:  st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign st = st_q;

    // R2
    dset_hits_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_DSET) |=>
            ((st_q.dout & $past(wr_data)) == $past(wr_data)) &&
            ((st_q.dout & ~$past(wr_data)) == ($past(st_q.dout) & ~$past(wr_data))));

    // R3
    dclr_hits_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_DCLR) |=>
            ((st_q.dout & $past(wr_data)) == '0) &&
            ((st_q.dout & ~$past(wr_data)) == ($past(st_q.dout) & ~$past(wr_data))));

    // R4
    dir_set_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_DIRS) |=> ((st_q.dir & $past(wr_data)) == $past(wr_data)));

    // R4
    dir_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_DIRC) |=> ((st_q.dir & $past(wr_data)) == '0));

    // R9
    unmapped_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_NONE) |=> $stable(st_q));

    // R10
    data_wr_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_DATA) |=> $stable(st_q));

endmodule

// File: rtl/gpb_readmux.sv
module gpb_readmux
    import gpb_pkg::*;
(
    input  reg_sel_e         sel,
    input  port_state_t      st,
    input  logic [PIN_N-1:0] pin_lvl,
    output logic [PIN_N-1:0] rd_data
);

    always_comb begin
        case (sel)
            SEL_DATA: rd_data = pin_lvl;
            SEL_PDIS: rd_data = st.pull_dis;
            SEL_DIR:  rd_data = st.dir;
            SEL_SLP:  rd_data = st.sleep_keep;
            SEL_ALTA: rd_data = st.alt_a;
            SEL_ALTB: rd_data = st.alt_b;
            default:  rd_data = '0;
        endcase
    end

    // R9
    always_comb begin
        if (sel == SEL_DSET || sel == SEL_DCLR || sel == SEL_DIRS ||
            sel == SEL_DIRC || sel == SEL_NONE) begin
            strobe_reads_zero_chk: assert (rd_data == '0);
        end
    end

endmodule

// File: rtl/gpb_padmap.sv
module gpb_padmap
    import gpb_pkg::*;
(
    input  port_state_t       st,
    output logic [PIN_N-1:0]  pad_out,
    output logic [PIN_N-1:0]  pad_oe,
    output logic [PIN_N-1:0]  pad_pull_en,
    output logic [PIN_N-1:0]  pad_sleep_keep,
    output logic [FUNC_W-1:0] pad_func
);

    assign pad_out        = st.dout;
    assign pad_oe         = st.dir;
    assign pad_pull_en    = ~st.pull_dis;
    assign pad_sleep_keep = st.sleep_keep;

    for (genvar i = 0; i < PIN_N; i++) begin : g_pin
        pin_fn_e fn;
        assign fn = pin_fn(st.alt_a[i], st.alt_b[i]);
        assign pad_func[i*FN_W +: FN_W] = fn;

        // R6
        always_comb begin
            fn_gpio_chk: assert ((fn == FN_GPIO) == (!st.alt_a[i] && !st.alt_b[i]));
        end
    end

endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank
    import gpb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [PIN_N-1:0]  wr_data,
    output logic [PIN_N-1:0]  rd_data,
    input  logic [PIN_N-1:0]  pin_in,
    output logic [PIN_N-1:0]  pad_out,
    output logic [PIN_N-1:0]  pad_oe,
    output logic [PIN_N-1:0]  pad_pull_en,
    output logic [PIN_N-1:0]  pad_sleep_keep,
    output logic [FUNC_W-1:0] pad_func
);

    reg_sel_e         sel;
    port_state_t      st;
    logic [PIN_N-1:0] pin_lvl;

    assign sel = decode_addr(addr);

    gpb_sync #(.W(PIN_N)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (pin_lvl)
    );

    gpb_regfile u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .sel     (sel),
        .wr_data (wr_data),
        .st      (st)
    );

    gpb_readmux u_rd (
        .sel     (sel),
        .st      (st),
        .pin_lvl (pin_lvl),
        .rd_data (rd_data)
    );

    gpb_padmap u_pad (
        .st             (st),
        .pad_out        (pad_out),
        .pad_oe         (pad_oe),
        .pad_pull_en    (pad_pull_en),
        .pad_sleep_keep (pad_sleep_keep),
        .pad_func       (pad_func)
    );

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (pad_oe == '0) && (pad_out == '0) && (pad_func == '0) && (pad_pull_en == '1));

endmodule

// File: tb/tb_gpio_port_bank.sv
`timescale 1ns/1ps
module tb_gpio_port_bank;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [31:0] pin_in = '0;
    logic [31:0] pad_out, pad_oe, pad_pull_en, pad_sleep_keep;
    logic [63:0] pad_func;

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] m_dout = '0;
    logic [31:0] m_dir  = '0;

    always #2.5 clk = ~clk;

    gpio_port_bank dut (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .pin_in(pin_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .pad_pull_en(pad_pull_en), .pad_sleep_keep(pad_sleep_keep), .pad_func(pad_func)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd_chk(input string req, input logic [5:0] a, input logic [31:0] exp);
        addr = a;
        #0.5;
        chk(req, {32'd0, rd_data}, {32'd0, exp});
    endtask

    task automatic t_reset;
        rd_chk("R1 dir", 6'h10, 32'h0);
        rd_chk("R1 pull", 6'h0C, 32'h0);
        rd_chk("R1 sleep", 6'h1C, 32'h0);
        rd_chk("R1 altA", 6'h20, 32'h0);
        rd_chk("R1 altB", 6'h24, 32'h0);
        chk("R1 pad_out", {32'd0, pad_out}, 64'd0);
        chk("R1 pad_oe", {32'd0, pad_oe}, 64'd0);
        chk("R1 pad_func", pad_func, 64'd0);
        chk("R1 pull_en", {32'd0, pad_pull_en}, {32'd0, 32'hFFFF_FFFF});
    endtask

    task automatic t_data_set;
        wr(6'h04, 32'hA5A5_0000); m_dout |= 32'hA5A5_0000;
        chk("R2 set first", {32'd0, pad_out}, {32'd0, m_dout});
        wr(6'h04, 32'h0000_00F0); m_dout |= 32'h0000_00F0;
        chk("R2 set keeps others", {32'd0, pad_out}, {32'd0, m_dout});
        rd_chk("R9 dset reads 0", 6'h04, 32'h0);
    endtask

    task automatic t_data_clear;
        wr(6'h08, 32'h8000_00A0); m_dout &= ~32'h8000_00A0;
        chk("R3 clear", {32'd0, pad_out}, {32'd0, m_dout});
        wr(6'h08, 32'h0000_0000);
        chk("R3 clear zero no change", {32'd0, pad_out}, {32'd0, m_dout});
        rd_chk("R9 dclr reads 0", 6'h08, 32'h0);
    endtask

    task automatic t_dir;
        wr(6'h14, 32'hFFFF_0000); m_dir |= 32'hFFFF_0000;
        rd_chk("R4 dir after set", 6'h10, m_dir);
        wr(6'h18, 32'h0F00_0001); m_dir &= ~32'h0F00_0001;
        rd_chk("R4 dir after clear", 6'h10, m_dir);
        chk("R4 pad_oe", {32'd0, pad_oe}, {32'd0, m_dir});
        rd_chk("R9 dirs reads 0", 6'h14, 32'h0);
        rd_chk("R9 dirc reads 0", 6'h18, 32'h0);
        chk("R10 pad_out independent of dir", {32'd0, pad_out}, {32'd0, m_dout});
    endtask

    task automatic t_pin_read;
        @(negedge clk);
        addr = 6'h00;
        pin_in = 32'h1357_9BDF;
        @(negedge clk);
        rd_chk("R5 one edge still old", 6'h00, 32'h0);
        @(negedge clk);
        rd_chk("R5 two edges new", 6'h00, 32'h1357_9BDF);
        pin_in = 32'hFFFF_0000;
        @(negedge clk);
        @(negedge clk);
        rd_chk("R5 second pattern", 6'h00, 32'hFFFF_0000);
    endtask

    task automatic t_alt;
        wr(6'h20, 32'h8000_000A);
        wr(6'h24, 32'h4000_000C);
        rd_chk("R6 altA readback", 6'h20, 32'h8000_000A);
        rd_chk("R6 altB readback", 6'h24, 32'h4000_000C);
        chk("R6 pins0-3 codes", {56'd0, pad_func[7:0]}, {56'd0, 8'hE4});
        chk("R6 pin31 fnA", {62'd0, pad_func[63:62]}, 64'd1);
        chk("R6 pin30 fnB", {62'd0, pad_func[61:60]}, 64'd2);
        chk("R6 middle gpio", {8'd0, pad_func[59:8]}, 64'd0);
    endtask

    task automatic t_pull_sleep;
        wr(6'h0C, 32'h1234_5678);
        rd_chk("R7 pull readback", 6'h0C, 32'h1234_5678);
        chk("R7 pull_en inverse", {32'd0, pad_pull_en}, {32'd0, ~32'h1234_5678});
        wr(6'h1C, 32'hCAFE_0001);
        rd_chk("R8 sleep readback", 6'h1C, 32'hCAFE_0001);
        chk("R8 sleep pad", {32'd0, pad_sleep_keep}, {32'd0, 32'hCAFE_0001});
    endtask

    task automatic t_ignored;
        wr(6'h00, 32'hFFFF_FFFF);
        chk("R10 data write ignored", {32'd0, pad_out}, {32'd0, m_dout});
        wr(6'h28, 32'hFFFF_FFFF);
        wr(6'h3C, 32'hFFFF_FFFF);
        wr(6'h05, 32'hFFFF_FFFF);
        chk("R9 unmapped pad_out", {32'd0, pad_out}, {32'd0, m_dout});
        chk("R9 unmapped pad_oe", {32'd0, pad_oe}, {32'd0, m_dir});
        rd_chk("R9 unmapped pull", 6'h0C, 32'h1234_5678);
        rd_chk("R9 unmapped altA", 6'h20, 32'h8000_000A);
        rd_chk("R9 unmapped read", 6'h28, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_data_set();
        t_data_clear();
        t_dir();
        t_pin_read();
        t_alt();
        t_pull_sleep();
        t_ignored();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule